// File: doc/BRIEF.md
# Multi-Mode Parallel Input Sampler

This block captures a parallel input word and hands each sample to the write side of an input FIFO. The word is 8, 16 or 32 bits wide. Narrow samples are zero-extended so that every sample fills exactly one 32-bit FIFO entry. The FIFO, the DMA engine and the host bus all sit outside the block. The block drives the FIFO's write enable, write data and flush lines, and it reads the FIFO's full flag.

The capture pacing is chosen from five modes:

- **Three internal pacers:**
  - a fast tick (20 MHz at the intended clock);
  - a half-rate tick (10 MHz);
  - the half-rate tick divided by a 16-bit programmable divisor.
- **External strobe:** a strobe on the request line samples one word per active edge. The active edge, rising or falling, is selectable.
- **Four-phase handshake:** the request and acknowledge lines carry a request/acknowledge exchange with the external device.

A start option makes capture wait for an external trigger rather than begin at once. The request, acknowledge and trigger lines each have a polarity-inversion control. A sticky overrun flag records any sample that arrived while the FIFO was full.

Top module: `din_sampler`

## Requirements
- R1: `cfg_width` selects the sample width: 2'b00 takes `din[7:0]`, 2'b01 takes `din[15:0]`, and 2'b10 or 2'b11 takes all 32 bits. The unused upper bits of `fifo_wr_data` are zero.
- R2: With `cfg_pace` = 0 (fast pacer), consecutive writes are exactly `FAST_DIV` clock cycles apart (10 by default).
- R3: With `cfg_pace` = 1 (half-rate pacer), consecutive writes are exactly 2*`FAST_DIV` cycles apart.
- R4: With `cfg_pace` = 2 (programmable pacer), consecutive writes are 2*`FAST_DIV`*N cycles apart. N is `cfg_divisor`, and a divisor of 0 counts as 1.
- R5: With `cfg_pace` = 3 (strobe), each active edge of the polarity-corrected request produces one write of the word present at that edge. The active edge is rising when `cfg_edge_fall` = 0 and falling when it is 1.
- R6: With `cfg_pace` = 4 (handshake), an active request causes one write and raises acknowledge. Acknowledge stays active while the request stays active. Acknowledge drops only after the request is released. Exactly one word is taken per exchange.
- R7: With `cfg_start_trig` = 1, nothing is written until the polarity-corrected trigger goes from inactive to active. Capture then continues until `cfg_enable` drops, and dropping `cfg_enable` re-arms the trigger wait.
- R8: Setting `cfg_req_inv`, `cfg_ack_inv` or `cfg_trig_inv` to 1 makes the corresponding line active low. When 0, the line is active high.
- R9: A sample that arrives while `fifo_full` is high is not written and sets `overrun`. `overrun` stays set until it is cleared.
- R10: While `cfg_enable` is low, `fifo_wr_en` stays low in every following cycle.
- R11: A one-cycle `cfg_clear` pulse produces a one-cycle `fifo_flush` on the next cycle and clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Gates all capture |
| cfg_clear | input | 1 | Pulse: flush FIFO, clear overrun |
| cfg_width | input | 2 | Sample width select |
| cfg_pace | input | 3 | Pacing mode select |
| cfg_edge_fall | input | 1 | Strobe mode: 1 selects the falling edge |
| cfg_start_trig | input | 1 | 1: wait for trigger before capture |
| cfg_req_inv | input | 1 | Request line active low |
| cfg_ack_inv | input | 1 | Acknowledge line active low |
| cfg_trig_inv | input | 1 | Trigger line active low |
| cfg_divisor | input | 16 | Programmable pacer divisor |
| din | input | 32 | Parallel input word |
| ext_req | input | 1 | External strobe / handshake request |
| ext_trig | input | 1 | External start trigger |
| ext_ack | output | 1 | Handshake acknowledge |
| fifo_full | input | 1 | FIFO full flag |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 32 | FIFO write word |
| fifo_flush | output | 1 | FIFO flush pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench measures the spacing between successive writes in each paced mode, including a divisor of zero. A pacer that is off by one cycle, or that treats zero as 65536, shows up as a wrong gap.

It drives the same four-step request sequence under all four combinations of edge select and request polarity. A design that swaps the edge, or applies polarity after edge detection, captures the wrong pair of words.

In handshake mode it holds the request active well past the acknowledge. A design that re-captures, or drops acknowledge early, writes extra words or shows acknowledge inactive.

It also checks three more cases: a trigger-gated start with an inverted trigger, which must stay silent until the edge arrives; writes attempted into a full FIFO, which must be suppressed while the overrun flag is set; and an overrun flag that must survive until an explicit clear.

// File: rtl/din_pkg.sv
// Shared encodings for the input sampler.
// Assumes: the encodings below match the values listed in the requirements.
package din_pkg;
    typedef enum logic [2:0] {
        PACE_FAST   = 3'd0,
        PACE_SLOW   = 3'd1,
        PACE_PROG   = 3'd2,
        PACE_STROBE = 3'd3,
        PACE_HAND   = 3'd4
    } pace_e;

    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_16 = 2'd1,
        WID_32 = 2'd2
    } width_e;
endpackage

// File: rtl/din_pace_gen.sv
// Internal pacer: the fast tick every FAST_DIV clocks, the half-rate tick on
// every second fast tick, and the programmable tick on every Nth half-rate tick.
// Assumes: FAST_DIV >= 2. All counters restart while run is low, so the tick
// phase is defined from the start of capture.
module din_pace_gen #(
    parameter int FAST_DIV = 10,
    parameter int DIV_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick_fast,
    output logic             tick_slow,
    output logic             tick_prog
);
    localparam int CW = $clog2(FAST_DIV);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_DIV - 1);

    logic [CW-1:0]    fast_cnt;
    logic             half_q;
    logic [DIV_W-1:0] prog_cnt;
    logic [DIV_W-1:0] prog_last;

    // Divisor 0 behaves as 1.
    assign prog_last = (divisor == '0) ? '0 : divisor - 1'b1;

    assign tick_fast = run && (fast_cnt == FAST_LAST);
    assign tick_slow = tick_fast && half_q;
    assign tick_prog = tick_slow && (prog_cnt >= prog_last);

    // Fast counter: wraps every FAST_DIV cycles while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  fast_cnt <= '0;
        else if (tick_fast)  fast_cnt <= '0;
        else                 fast_cnt <= fast_cnt + 1'b1;
    end

    // Half-rate phase: toggles on each fast tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  half_q <= 1'b0;
        else if (tick_fast)  half_q <= ~half_q;
    end

    // Programmable counter: counts half-rate ticks up to the divisor.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  prog_cnt <= '0;
        else if (tick_prog)  prog_cnt <= '0;
        else if (tick_slow)  prog_cnt <= prog_cnt + 1'b1;
    end
endmodule

// File: rtl/din_sig_sync.sv
// Two-flop synchronizer with polarity correction and edge detection for one
// control line.
// Assumes: the polarity is applied before the first flop, so a line that is
// idle at its inactive level never produces an edge after reset.
module din_sig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    input  logic inv,
    output logic level,
    output logic rise,
    output logic fall
);
    logic s1_q, s2_q, s3_q;

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= raw ^ inv;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign level = s2_q;
    assign rise  = s2_q & ~s3_q;
    assign fall  = ~s2_q & s3_q;
endmodule

// File: rtl/din_capture.sv
// Capture control: start arming, event selection per pacing mode, width
// masking, FIFO write, overrun flag, handshake acknowledge and flush pulse.
// Assumes: din is stable for at least four clocks after a strobe or request
// edge, so it is still valid when the synchronized edge is seen.
module din_capture
    import din_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              clear,
    input  logic [1:0]        width,
    input  logic [2:0]        pace,
    input  logic              edge_fall,
    input  logic              start_trig,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              tick_prog,
    input  logic              req_level,
    input  logic              req_rise,
    input  logic              req_fall,
    input  logic              trig_rise,
    input  logic [DATA_W-1:0] din,
    input  logic              fifo_full,
    output logic              running,
    output logic              ack_act,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              overrun,
    output logic              flush
);
    pace_e             mode;
    logic              hs_take;
    logic              evt;
    logic              sample;
    logic [DATA_W-1:0] masked;

    assign mode    = pace_e'(pace);
    assign hs_take = enable && (mode == PACE_HAND) && !ack_act && req_level;

    // Pick the capture event for the selected pacing mode.
    always_comb begin
        case (mode)
            PACE_FAST:   evt = tick_fast;
            PACE_SLOW:   evt = tick_slow;
            PACE_PROG:   evt = tick_prog;
            PACE_STROBE: evt = edge_fall ? req_fall : req_rise;
            PACE_HAND:   evt = hs_take;
            default:     evt = 1'b0;
        endcase
    end

    assign sample = enable && running && evt;

    // Zero-extend narrow samples into the full FIFO word.
    always_comb begin
        masked = '0;
        case (width_e'(width))
            WID_8:   masked[7:0]  = din[7:0];
            WID_16:  masked[15:0] = din[15:0];
            default: masked       = din;
        endcase
    end

    // Arming: immediate start, or wait for a trigger edge; cleared by disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)  running <= 1'b0;
        else if (!running)      running <= !start_trig || trig_rise;
    end

    // FIFO write: one cycle per accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= sample && !fifo_full;
            if (sample && !fifo_full) wr_data <= masked;
        end
    end

    // Sticky overrun: set by a sample into a full FIFO, cleared by clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  overrun <= 1'b0;
        else if (sample && fifo_full) overrun <= 1'b1;
        else if (clear)              overrun <= 1'b0;
    end

    // Handshake acknowledge: raise on take, drop once request is released.
    always_ff @(posedge clk) begin
        if (!rst_n || !running || mode != PACE_HAND) ack_act <= 1'b0;
        else if (hs_take)                            ack_act <= 1'b1;
        else if (ack_act && !req_level)              ack_act <= 1'b0;
    end

    // Flush pulse follows the clear request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) flush <= 1'b0;
        else        flush <= clear;
    end
endmodule

// File: rtl/din_sampler.sv
// Top of the multi-mode input sampler: pacer, two control-line synchronizers
// and the capture controller.
// Assumes: FIFO storage is external; fifo_full is synchronous to clk.
module din_sampler #(
    parameter int FAST_DIV = 10,
    parameter int DIV_W    = 16,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_clear,
    input  logic [1:0]        cfg_width,
    input  logic [2:0]        cfg_pace,
    input  logic              cfg_edge_fall,
    input  logic              cfg_start_trig,
    input  logic              cfg_req_inv,
    input  logic              cfg_ack_inv,
    input  logic              cfg_trig_inv,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic [DATA_W-1:0] din,
    input  logic              ext_req,
    input  logic              ext_trig,
    output logic              ext_ack,
    input  logic              fifo_full,
    output logic              fifo_wr_en,
    output logic [DATA_W-1:0] fifo_wr_data,
    output logic              fifo_flush,
    output logic              overrun
);
    logic tick_fast, tick_slow, tick_prog;
    logic req_level, req_rise, req_fall;
    logic trig_level, trig_rise, trig_fall;
    logic running, ack_act;

    din_pace_gen #(.FAST_DIV(FAST_DIV), .DIV_W(DIV_W)) i_pace (
        .clk(clk), .rst_n(rst_n), .run(cfg_enable && running),
        .divisor(cfg_divisor), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .tick_prog(tick_prog)
    );

    din_sig_sync i_req_sync (
        .clk(clk), .rst_n(rst_n), .raw(ext_req), .inv(cfg_req_inv),
        .level(req_level), .rise(req_rise), .fall(req_fall)
    );

    din_sig_sync i_trig_sync (
        .clk(clk), .rst_n(rst_n), .raw(ext_trig), .inv(cfg_trig_inv),
        .level(trig_level), .rise(trig_rise), .fall(trig_fall)
    );

    din_capture #(.DATA_W(DATA_W)) i_cap (
        .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .clear(cfg_clear),
        .width(cfg_width), .pace(cfg_pace), .edge_fall(cfg_edge_fall),
        .start_trig(cfg_start_trig), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .tick_prog(tick_prog),
        .req_level(req_level), .req_rise(req_rise), .req_fall(req_fall),
        .trig_rise(trig_rise), .din(din), .fifo_full(fifo_full),
        .running(running), .ack_act(ack_act), .wr_en(fifo_wr_en),
        .wr_data(fifo_wr_data), .overrun(overrun), .flush(fifo_flush)
    );

    // Acknowledge polarity is applied at the pin.
    assign ext_ack = ack_act ^ cfg_ack_inv;
endmodule

// File: rtl/din_sampler_chk.sv
// Property checker for din_sampler, attached through bind.
// Assumes: only observes; drives nothing.
module din_sampler_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_enable,
    input logic              cfg_clear,
    input logic [1:0]        cfg_width,
    input logic [2:0]        cfg_pace,
    input logic              fifo_full,
    input logic              fifo_wr_en,
    input logic [DATA_W-1:0] fifo_wr_data,
    input logic              fifo_flush,
    input logic              overrun,
    input logic              running,
    input logic              ack_act,
    input logic              req_level
);
    AST_ZERO_EXT_8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_en && $past(cfg_width) == 2'd0) |-> (fifo_wr_data[DATA_W-1:8] == '0)); // R1
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cfg_pace == 3'd4 && ack_act && req_level) |=> ack_act); // R6
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_act) |-> $past(req_level)); // R6
    AST_IDLE_UNTIL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !fifo_wr_en); // R7
    AST_NO_WRITE_INTO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> !$past(fifo_full)); // R9
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !cfg_clear) |=> overrun); // R9
    AST_NO_WRITE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !fifo_wr_en); // R10
    AST_FLUSH_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> fifo_flush); // R11
endmodule

bind din_sampler din_sampler_chk #(.DATA_W(DATA_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_clear(cfg_clear),
    .cfg_width(cfg_width), .cfg_pace(cfg_pace), .fifo_full(fifo_full),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
    .fifo_flush(fifo_flush), .overrun(overrun), .running(running),
    .ack_act(ack_act), .req_level(req_level)
);

// File: tb/test_din_sampler.sv
`timescale 1ns/1ps
// Directed bench for din_sampler: one task per scenario, each self-checking.
module test_din_sampler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b0, cfg_clear = 1'b0;
    logic [1:0]  cfg_width = 2'd2;
    logic [2:0]  cfg_pace = 3'd0;
    logic        cfg_edge_fall = 1'b0, cfg_start_trig = 1'b0;
    logic        cfg_req_inv = 1'b0, cfg_ack_inv = 1'b0, cfg_trig_inv = 1'b0;
    logic [15:0] cfg_divisor = 16'd0;
    logic [31:0] din = 32'h0;
    logic        ext_req = 1'b0, ext_trig = 1'b0, fifo_full = 1'b0;
    logic        ext_ack, fifo_wr_en, fifo_flush, overrun;
    logic [31:0] fifo_wr_data;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    int cyc = 0;
    int wr_n = 0;
    int wr_cyc [0:511];
    logic [31:0] wr_dat [0:511];

    always #2.5 clk = ~clk;

    din_sampler i_din_sampler (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_clear(cfg_clear),
        .cfg_width(cfg_width), .cfg_pace(cfg_pace), .cfg_edge_fall(cfg_edge_fall),
        .cfg_start_trig(cfg_start_trig), .cfg_req_inv(cfg_req_inv),
        .cfg_ack_inv(cfg_ack_inv), .cfg_trig_inv(cfg_trig_inv),
        .cfg_divisor(cfg_divisor), .din(din), .ext_req(ext_req),
        .ext_trig(ext_trig), .ext_ack(ext_ack), .fifo_full(fifo_full),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .fifo_flush(fifo_flush), .overrun(overrun)
    );

    // Write monitor: logs cycle and data of every FIFO write.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && fifo_wr_en && wr_n < 512) begin
            wr_cyc[wr_n] <= cyc;
            wr_dat[wr_n] <= fifo_wr_data;
            wr_n <= wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic t_reset();
        chk(!fifo_wr_en, "R10", "reset wr_en", 32'(fifo_wr_en), 0);
        chk(!overrun, "R9", "reset overrun", 32'(overrun), 0);
        chk(!ext_ack && !fifo_flush, "R6", "reset ack/flush", {ext_ack, fifo_flush}, 0);
    endtask

    // Paced capture: check write spacing and data.
    task automatic t_paced(input logic [2:0] pace, input logic [15:0] div,
                           input int gap, input string req);
        int base, n, bad;
        cfg_pace = pace; cfg_divisor = div; cfg_width = 2'd2; din = 32'hC0DE_0000 + 32'(gap);
        base = wr_n;
        cfg_enable = 1'b1;
        wait_cyc(gap * 4 + 10);
        cfg_enable = 1'b0;
        wait_cyc(4);
        n = wr_n - base;
        chk(n >= 3, req, "paced write count", n, 3);
        bad = 0;
        for (int i = base + 1; i < wr_n; i++)
            if (wr_cyc[i] - wr_cyc[i-1] != gap) bad++;
        chk(bad == 0, req, "paced gap errors", bad, 0);
        chk(wr_dat[base] == din, req, "paced data", wr_dat[base], din);
    endtask

    task automatic t_width(input logic [1:0] w, input logic [31:0] exp);
        int base, bad;
        cfg_pace = 3'd0; cfg_width = w; din = 32'hA5A5_5A3C;
        base = wr_n;
        cfg_enable = 1'b1;
        wait_cyc(45);
        cfg_enable = 1'b0;
        wait_cyc(4);
        bad = 0;
        for (int i = base; i < wr_n; i++) if (wr_dat[i] != exp) bad++;
        chk(wr_n > base && bad == 0, "R1", "width masked data", wr_dat[base], exp);
    endtask

    // Strobe: corrected rise, fall, rise, fall with words A, B, C, D.
    task automatic t_strobe(input bit fall, input bit inv, input bit en,
                            input logic [31:0] e0, input logic [31:0] e1, input string req);
        int base;
        cfg_enable = 1'b0; cfg_pace = 3'd3; cfg_width = 2'd2;
        cfg_edge_fall = fall; cfg_req_inv = inv; ext_req = inv;
        wait_cyc(6);
        base = wr_n;
        cfg_enable = en;
        wait_cyc(3);
        din = 32'hAAAA_0001; ext_req = ~inv; wait_cyc(6);
        din = 32'hBBBB_0002; ext_req = inv;  wait_cyc(6);
        din = 32'hCCCC_0003; ext_req = ~inv; wait_cyc(6);
        din = 32'hDDDD_0004; ext_req = inv;  wait_cyc(6);
        cfg_enable = 1'b0;
        wait_cyc(2);
        if (!en) begin
            chk(wr_n == base, "R10", "writes while disabled", wr_n - base, 0);
        end else begin
            chk(wr_n - base == 2, req, "strobe write count", wr_n - base, 2);
            chk(wr_dat[base] == e0, req, "strobe first word", wr_dat[base], e0);
            chk(wr_dat[base+1] == e1, req, "strobe second word", wr_dat[base+1], e1);
        end
        cfg_req_inv = 1'b0; ext_req = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_trigger();
        int base;
        cfg_pace = 3'd0; cfg_width = 2'd2; din = 32'h7777_1111;
        cfg_start_trig = 1'b1; cfg_trig_inv = 1'b1; ext_trig = 1'b1;
        wait_cyc(6);
        base = wr_n;
        cfg_enable = 1'b1;
        wait_cyc(60);
        chk(wr_n == base, "R7", "writes before trigger", wr_n - base, 0);
        ext_trig = 1'b0; wait_cyc(3); ext_trig = 1'b1;
        wait_cyc(60);
        chk(wr_n - base >= 4, "R8", "writes after active-low trigger", wr_n - base, 4);
        cfg_enable = 1'b0;
        wait_cyc(4);
        base = wr_n;
        cfg_enable = 1'b1;
        wait_cyc(40);
        chk(wr_n == base, "R7", "re-armed after disable", wr_n - base, 0);
        cfg_enable = 1'b0; cfg_start_trig = 1'b0; cfg_trig_inv = 1'b0; ext_trig = 1'b0;
        wait_cyc(4);
    endtask

    task automatic hs_exchange(input logic [31:0] word);
        int base, t;
        base = wr_n;
        din = word; ext_req = 1'b1;
        t = 0;
        while (ext_ack != 1'b0 && t < 20) begin wait_cyc(1); t++; end
        chk(ext_ack == 1'b0, "R8", "active-low ack asserted", 32'(ext_ack), 0);
        wait_cyc(10);
        chk(ext_ack == 1'b0, "R6", "ack held while req active", 32'(ext_ack), 0);
        chk(wr_n - base == 1, "R6", "one word per exchange", wr_n - base, 1);
        chk(wr_dat[base] == word, "R6", "handshake word", wr_dat[base], word);
        ext_req = 1'b0;
        t = 0;
        while (ext_ack != 1'b1 && t < 20) begin wait_cyc(1); t++; end
        chk(ext_ack == 1'b1, "R6", "ack released after req", 32'(ext_ack), 1);
    endtask

    task automatic t_handshake();
        cfg_pace = 3'd4; cfg_width = 2'd2; cfg_ack_inv = 1'b1; ext_req = 1'b0;
        wait_cyc(2);
        chk(ext_ack == 1'b1, "R8", "idle ack inverted", 32'(ext_ack), 1);
        cfg_enable = 1'b1;
        wait_cyc(3);
        hs_exchange(32'h1234_5678);
        wait_cyc(3);
        hs_exchange(32'h9ABC_DEF0);
        cfg_enable = 1'b0; cfg_ack_inv = 1'b0;
        wait_cyc(4);
    endtask

    task automatic t_overrun();
        int base;
        cfg_pace = 3'd0; cfg_width = 2'd2; fifo_full = 1'b1;
        base = wr_n;
        cfg_enable = 1'b1;
        wait_cyc(40);
        chk(wr_n == base, "R9", "no write into full FIFO", wr_n - base, 0);
        chk(overrun == 1'b1, "R9", "overrun set", 32'(overrun), 1);
        cfg_enable = 1'b0; fifo_full = 1'b0;
        wait_cyc(8);
        chk(overrun == 1'b1, "R9", "overrun sticky", 32'(overrun), 1);
        cfg_clear = 1'b1; wait_cyc(1); cfg_clear = 1'b0;
        chk(fifo_flush == 1'b1, "R11", "flush pulse", 32'(fifo_flush), 1);
        chk(overrun == 1'b0, "R11", "overrun cleared", 32'(overrun), 0);
        wait_cyc(1);
        chk(fifo_flush == 1'b0, "R11", "flush one cycle", 32'(fifo_flush), 0);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_paced(3'd0, 16'd0, 10, "R2");
        t_paced(3'd1, 16'd0, 20, "R3");
        t_paced(3'd2, 16'd3, 60, "R4");
        t_paced(3'd2, 16'd0, 20, "R4");
        t_width(2'd0, 32'h0000_003C);
        t_width(2'd1, 32'h0000_5A3C);
        t_width(2'd3, 32'hA5A5_5A3C);
        t_strobe(1'b0, 1'b0, 1'b1, 32'hAAAA_0001, 32'hCCCC_0003, "R5");
        t_strobe(1'b1, 1'b0, 1'b1, 32'hBBBB_0002, 32'hDDDD_0004, "R5");
        t_strobe(1'b0, 1'b1, 1'b1, 32'hAAAA_0001, 32'hCCCC_0003, "R8");
        t_strobe(1'b1, 1'b1, 1'b1, 32'hBBBB_0002, 32'hDDDD_0004, "R8");
        t_strobe(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, "R10");
        t_trigger();
        t_handshake();
        t_overrun();
        done = 1'b1;
        finish_run();
    end
endmodule